// File: doc/BRIEF.md
# Test-Rate Tick Ladder and Site Status Display

This block sits beside four parallel device test sites. From the master clock (50 MHz by default) it builds a ladder of clock-enable ticks, each one clock cycle wide. A free-running binary counter supplies the divide-by-2, 4, 8, 16 and 32 rates (25, 12.5, 6.25, 3.125 and about 1.56 MHz). Two modulo counters add a 0.5 MHz tick and a 2 Hz tick. A fast/user mode input chooses the test-rate tick. In fast mode it is the binary rate fixed by a parameter. In user mode it is the 2 Hz tick, so that a person can follow the results.

A 3-bit select chooses which site is reported. The LED word takes that site's last observed output byte on each test-rate tick. Four character outputs, in ASCII, spell "IC", then the site digit, then a status letter. The status letter is P for pass, F for fail, or a dash while the site is still running.

Top module: `site_status_ticker`

## Requirements
- R1: While reset (rst_n low) is held, every tick is low, the LED word is 0 and all four character outputs are the space code 0x20.
- R2: Ladder bit k, for k from 0 to DIV_STAGES-1, is high exactly in the cycles where n+1 is a multiple of 2^(k+1). Here n counts rising clock edges since reset was released.
- R3: Ladder bit DIV_STAGES (the slow tick) is high exactly when n mod SLOW_DIV equals SLOW_DIV-1. Ladder bit DIV_STAGES+1 (the human-rate tick) is high exactly when n mod HUMAN_DIV equals HUMAN_DIV-1.
- R4: Every tick is one cycle wide. All ticks restart in phase after reset, so they are all high together whenever every divider wraps at once.
- R5: rate_tick equals ladder bit FAST_SEL while fast_mode is 1, and equals the human-rate tick while fast_mode is 0.
- R6: With a valid select, the LED word loads the selected site's byte at each edge where rate_tick is high, and holds its value at every other edge.
- R7: Select codes 1, 2, 3 and 4 pick sites 1 to 4. Site s uses bits [8s-1:8s-8] of site_obs and bit s-1 of the pass, fail and done flags.
- R8: With a valid select, one edge later disp0 is 'I' (0x49), disp1 is 'C' (0x43) and disp2 is the ASCII site digit (0x31 to 0x34).
- R9: disp3 is 'F' (0x46) whenever the selected fail flag is set, whatever the other flags are. Otherwise it is 'P' (0x50) when both done and pass are set, and '-' (0x2D) in every other case.
- R10: Select codes 0, 5, 6 and 7 set all four character outputs to 0x20 and the LED word to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | 1 selects the fast test rate, 0 selects the human rate |
| site_sel | input | 3 | Site whose status is shown |
| site_pass | input | 4 | Per-site pass flags, bit s-1 for site s |
| site_fail | input | 4 | Per-site fail flags |
| site_done | input | 4 | Per-site test-complete flags |
| site_obs | input | 4*OBS_W | Per-site observed output bytes |
| tick_ladder | output | DIV_STAGES+2 | Binary ticks, then the slow tick, then the human-rate tick |
| rate_tick | output | 1 | Chosen test-rate tick |
| led | output | OBS_W | Displayed observed-output word |
| disp0 | output | 8 | Leftmost character (ASCII) |
| disp1 | output | 8 | Second character |
| disp2 | output | 8 | Third character |
| disp3 | output | 8 | Rightmost status character |

## Verification
The assertions assume that SLOW_DIV and HUMAN_DIV are at least 2, so that no tick can stay high for two cycles. They also assume that the site inputs are steady during each cycle, since status and LED checks compare one edge against the next. The bench changes every input only on the falling clock edge. It scales the dividers down (SLOW_DIV 10, HUMAN_DIV 40) so that full periods fit in a short run, and it keeps the select within 0 to 7. Fail flags are driven both alone and together with pass and done, to check the priority between the status letters.

// File: rtl/site_status_ticker.sv
module site_status_ticker #(
  parameter int DIV_STAGES = 5,
  parameter int SLOW_DIV   = 100,
  parameter int HUMAN_DIV  = 25_000_000,
  parameter int FAST_SEL   = 0,
  parameter int OBS_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fast_mode,
  input  logic [2:0]              site_sel,
  input  logic [3:0]              site_pass,
  input  logic [3:0]              site_fail,
  input  logic [3:0]              site_done,
  input  logic [4*OBS_W-1:0]      site_obs,
  output logic [DIV_STAGES+1:0]   tick_ladder,
  output logic                    rate_tick,
  output logic [OBS_W-1:0]        led,
  output logic [7:0]              disp0,
  output logic [7:0]              disp1,
  output logic [7:0]              disp2,
  output logic [7:0]              disp3
);
  localparam int SW = $clog2(SLOW_DIV);
  localparam int HW = $clog2(HUMAN_DIV);
  localparam logic [7:0] CH_BLANK = 8'h20;

  logic [DIV_STAGES-1:0] bin_cnt;
  logic [SW-1:0]         slow_cnt;
  logic [HW-1:0]         hum_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_cnt  <= '0;
      slow_cnt <= '0;
      hum_cnt  <= '0;
    end else begin
      bin_cnt  <= bin_cnt + 1'b1;
      slow_cnt <= (slow_cnt == SW'(SLOW_DIV - 1)) ? '0 : slow_cnt + 1'b1;
      hum_cnt  <= (hum_cnt == HW'(HUMAN_DIV - 1)) ? '0 : hum_cnt + 1'b1;
    end
  end

  for (genvar k = 0; k < DIV_STAGES; k++) begin : g_bin_tick
    assign tick_ladder[k] = &bin_cnt[k:0];
  end
  assign tick_ladder[DIV_STAGES]   = (slow_cnt == SW'(SLOW_DIV - 1));
  assign tick_ladder[DIV_STAGES+1] = (hum_cnt == HW'(HUMAN_DIV - 1));

  assign rate_tick = fast_mode ? tick_ladder[FAST_SEL] : tick_ladder[DIV_STAGES+1];

  logic             sel_ok;
  logic [1:0]       idx;
  logic [OBS_W-1:0] obs_pick;
  logic [7:0]       status_ch;

  assign sel_ok    = (site_sel >= 3'd1) && (site_sel <= 3'd4);
  assign idx       = 2'(site_sel - 3'd1);
  assign obs_pick  = site_obs[idx*OBS_W +: OBS_W];
  assign status_ch = site_fail[idx]                    ? 8'h46 :
                     (site_done[idx] && site_pass[idx]) ? 8'h50 : 8'h2D;

  always_ff @(posedge clk) begin
    if (!rst_n || !sel_ok) begin
      led   <= '0;
      disp0 <= CH_BLANK;
      disp1 <= CH_BLANK;
      disp2 <= CH_BLANK;
      disp3 <= CH_BLANK;
    end else begin
      disp0 <= 8'h49;
      disp1 <= 8'h43;
      disp2 <= 8'h30 + {5'd0, site_sel};
      disp3 <= status_ch;
      if (rate_tick) led <= obs_pick;
    end
  end

  for (genvar t = 0; t < DIV_STAGES + 2; t++) begin : g_tick_chk
    assert_tick_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_ladder[t] |=> !tick_ladder[t]);
  end
  for (genvar t = 1; t < DIV_STAGES; t++) begin : g_phase_chk
    assert_ladder_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_ladder[t] |-> tick_ladder[t-1]);
  end

  assert_led_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && !rate_tick) |=> $stable(led));

  assert_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |=> (disp0 == 8'h49 && disp1 == 8'h43));

  assert_fail_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && site_fail[idx]) |=> disp3 == 8'h46);

  assert_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> (led == '0 && disp0 == 8'h20 && disp1 == 8'h20 &&
                 disp2 == 8'h20 && disp3 == 8'h20));
endmodule

// File: tb/site_status_ticker_tb_top.sv
module site_status_ticker_tb_top;
  localparam int S = 5, SL = 10, HU = 40, FS = 1;

  logic        clk = 0, rst_n = 0, fast_mode = 0;
  logic [2:0]  site_sel = 0;
  logic [3:0]  site_pass = 0, site_fail = 0, site_done = 0;
  logic [31:0] site_obs = 0;
  logic [S+1:0] tick_ladder;
  logic        rate_tick;
  logic [7:0]  led, disp0, disp1, disp2, disp3;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  site_status_ticker #(.DIV_STAGES(S), .SLOW_DIV(SL), .HUMAN_DIV(HU), .FAST_SEL(FS), .OBS_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .site_sel(site_sel),
    .site_pass(site_pass), .site_fail(site_fail), .site_done(site_done), .site_obs(site_obs),
    .tick_ladder(tick_ladder), .rate_tick(rate_tick), .led(led),
    .disp0(disp0), .disp1(disp1), .disp2(disp2), .disp3(disp3));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    while (!rate_tick) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(tick_ladder == 0 && rate_tick == 0, "R1 ticks", int'(tick_ladder), 0);
    chk(led == 0, "R1 led", led, 0);
    chk({disp0, disp1, disp2, disp3} == 32'h20202020, "R1 disp",
        int'({disp0, disp1, disp2, disp3}), 32'h20202020);
    rst_n = 1;
  endtask

  task automatic t_ladder();
    int bad [S+2];
    bit all_hi = 0;
    foreach (bad[i]) bad[i] = 0;
    for (int n = 1; n <= 200; n++) begin
      @(negedge clk);
      for (int k = 0; k < S; k++)
        if (tick_ladder[k] != (((n + 1) % (1 << (k + 1))) == 0)) bad[k]++;
      if (tick_ladder[S] != ((n % SL) == SL - 1)) bad[S]++;
      if (tick_ladder[S+1] != ((n % HU) == HU - 1)) bad[S+1]++;
      if (n == 159) all_hi = &tick_ladder;
    end
    for (int k = 0; k < S; k++) chk(bad[k] == 0, "R2 binary tick mismatches", bad[k], 0);
    chk(bad[S] == 0, "R3 slow tick mismatches", bad[S], 0);
    chk(bad[S+1] == 0, "R3 human tick mismatches", bad[S+1], 0);
    chk(all_hi, "R4 all ticks in phase", all_hi, 1);
  endtask

  task automatic t_rate_mode();
    int bad = 0, gap = 0;
    fast_mode = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rate_tick != tick_ladder[FS]) bad++;
    end
    chk(bad == 0, "R5 fast rate", bad, 0);
    fast_mode = 0;
    bad = 0;
    for (int i = 0; i < 90; i++) begin
      @(negedge clk);
      if (rate_tick != tick_ladder[S+1]) bad++;
    end
    chk(bad == 0, "R5 user rate", bad, 0);
    wait_tick();
    @(negedge clk);
    gap = 1;
    while (!rate_tick) begin @(negedge clk); gap++; end
    chk(gap == HU, "R5 user period", gap, HU);
  endtask

  task automatic t_led();
    fast_mode = 1;
    site_sel = 3;
    site_obs = 32'h11_22_33_44;
    @(negedge clk);
    wait_tick();
    site_obs[23:16] = 8'h3C;
    @(negedge clk);
    chk(led == 8'h3C, "R6 load on tick", led, 8'h3C);
    site_obs[23:16] = 8'hC3;
    @(negedge clk);
    chk(led == 8'h3C, "R6 hold without tick", led, 8'h3C);
    wait_tick();
    @(negedge clk);
    chk(led == 8'hC3, "R6 next tick", led, 8'hC3);
    site_sel = 1;
    wait_tick();
    @(negedge clk);
    chk(led == 8'h44, "R7 site1 byte", led, 8'h44);
    site_sel = 4;
    wait_tick();
    @(negedge clk);
    chk(led == 8'hC3 || led == 8'h11, "R7 site4 wait", led, 8'h11);
    wait_tick();
    @(negedge clk);
    chk(led == 8'h11, "R7 site4 byte", led, 8'h11);
  endtask

  task automatic t_disp(input logic [2:0] sel, input logic [3:0] p, input logic [3:0] f,
                        input logic [3:0] d, input logic [7:0] exp_st);
    site_sel = sel; site_pass = p; site_fail = f; site_done = d;
    @(negedge clk);
    chk(disp0 == 8'h49 && disp1 == 8'h43, "R8 prefix", int'({disp0, disp1}), 16'h4943);
    chk(disp2 == 8'h30 + sel, "R8 digit", disp2, 8'h30 + sel);
    chk(disp3 == exp_st, "R9 status", disp3, exp_st);
  endtask

  task automatic t_blank(input logic [2:0] sel);
    site_sel = 2;
    site_obs = 32'h5A5A5A5A;
    fast_mode = 1;
    @(negedge clk);
    wait_tick();
    @(negedge clk);
    site_sel = sel;
    @(negedge clk);
    chk(led == 0, "R10 led off", led, 0);
    chk({disp0, disp1, disp2, disp3} == 32'h20202020, "R10 blank",
        int'({disp0, disp1, disp2, disp3}), 32'h20202020);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ladder();
    t_rate_mode();
    t_led();
    t_disp(3'd1, 4'b0001, 4'b0000, 4'b0001, 8'h50);
    t_disp(3'd2, 4'b0000, 4'b0000, 4'b0000, 8'h2D);
    t_disp(3'd2, 4'b0010, 4'b0000, 4'b0000, 8'h2D);
    t_disp(3'd3, 4'b0100, 4'b0100, 4'b0100, 8'h46);
    t_disp(3'd4, 4'b0000, 4'b1000, 4'b0000, 8'h46);
    t_disp(3'd4, 4'b1000, 4'b0111, 4'b1000, 8'h50);
    t_blank(3'd0);
    t_blank(3'd5);
    t_blank(3'd6);
    t_blank(3'd7);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule